// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block drives the command bus of one DRAM channel. Read and write requests arrive with a bank, row, column and tag. They wait in a small queue. The scheduler turns each request into the activate, precharge and column-access commands it needs. It keeps a record of which row is open in each bank, and a busy countdown for each bank. At most one command leaves per cycle. When a column access goes out, a completion pulse carries the request's tag back.

Two mode pins control the selection and the page policy.

- Selection (`fifo_mode`):
  - In first-ready mode, a queued request whose row is already open goes ahead of older requests that would need a new row.
  - In strict FIFO mode, only the oldest request can make progress.
- Page policy (`close_page`):
  - With the open-page policy, a row stays open after a column access.
  - With the close-page policy, every column access carries an automatic precharge.

A refresh timer raises a periodic refresh. While the refresh is pending, open banks are precharged, no activate or column access is issued, and a refresh command goes out once every bank is closed and idle.

The request input is valid/ready. A requester holds `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge. `req_ready` depends only on how full the queue is. The command and completion outputs have no back-pressure: the bus takes one command in every cycle.

The mode pins should only change while the queue is empty and all banks are idle.

Top module: `dsch_top`

## Requirements
- R1: Command codes are ACT=0, RD=1, WR=2, PRE=3, REF=4. An ACT goes only to a closed bank. A RD or WR goes only to an open bank, and its `cmd_row` equals the row that bank's most recent ACT opened.
- R2: After a command to a bank, that bank takes no further command for a number of cycles set by the command: T_ACT (3) after ACT, T_PRE (3) after PRE, T_COL (1) after a column access, T_COL+T_PRE (4) after a column access with auto-precharge. After REF, no bank takes a command for T_RFC (8) cycles.
- R3: Each accepted request produces exactly one `done_valid` pulse carrying its tag. The pulse comes in the same cycle as the request's column command, which is WR if `req_write` was 1 and RD otherwise.
- R4: With `fifo_mode`=1, requests complete in the order they were accepted.
- R5: With `fifo_mode`=0, a ready request that hits an open row is issued before older requests that need a precharge or activate. Among equal candidates, the oldest wins.
- R6: With `close_page`=0, a row stays open after its access. A later request to the same row of that bank is served by a column command with no ACT first.
- R7: With `close_page`=1, every column command has `cmd_ap`=1. The next access to that bank starts with ACT and needs no PRE command.
- R8: Every REF_INT cycles a refresh becomes pending. While it is pending:
  - no ACT, RD or WR is issued;
  - open banks are precharged;
  - REF is issued only when all banks are closed.

  When the bus is idle and no row is open, successive REF commands are exactly REF_INT cycles apart.
- R9: The queue holds DEPTH (8) requests. `req_ready` is low exactly when DEPTH requests are outstanding. A held request is never lost.
- R10: For eight back-to-back requests to bank 0 that alternate between rows 1 and 2, first-ready mode finishes in fewer cycles than FIFO mode.
- R11: After reset, all banks are closed, the queue is empty (`req_ready`=1), and `cmd_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects strict FIFO order, 0 selects first-ready |
| close_page | input | 1 | 1 selects auto-precharge after each column access |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_tag | input | TAG_W | Tag returned on completion |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_kind | output | 3 | Command code (see R1) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for ACT/RD/WR/PRE |
| cmd_col | output | COL_W | Column for RD/WR |
| cmd_ap | output | 1 | Auto-precharge on a column command |
| done_valid | output | 1 | A request completes this cycle |
| done_tag | output | TAG_W | Tag of the completing request |

## Verification
A corrupted open-row record shows up at the next command to that bank: an ACT to a bank that is already open, or a column access naming the wrong row. A stuck busy countdown shows up either as a command that arrives too soon after the previous one to its bank, or as a queue that stops draining. Wrong age ordering shows up in the completion tag sequence within a few cycles of the first row hit. A refresh that fails to block shows up as a column or activate between the refresh becoming pending and the REF command.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } cmd_e;
endpackage

// File: rtl/dsch_queue.sv
// Age-ordered request store: slot 0 is oldest; removal compacts younger slots down.
module dsch_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [W-1:0]              push_data,
  input  logic                      pop,
  input  logic [IDX_W-1:0]          pop_idx,
  output logic [DEPTH-1:0][W-1:0]   slots,
  output logic [DEPTH-1:0]          slot_vld,
  output logic [CNT_W-1:0]          count,
  output logic                      full
);
  logic [DEPTH-1:0][W-1:0] mem;
  logic [DEPTH:0][W-1:0]   ext;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        wr_pos;

  assign ext    = {W'(0), mem};
  assign wr_pos = cnt - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && (IDX_W'(i) >= pop_idx)) mem[i] <= ext[i+1];
      end
      if (push) mem[wr_pos[IDX_W-1:0]] <= push_data;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign slot_vld[g] = (CNT_W'(g) < cnt);
    end
  endgenerate

  assign slots = mem;
  assign count = cnt;
  assign full  = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/dsch_bank.sv
// Per-bank open-row record and busy countdown.
module dsch_bank #(
  parameter int ROW_W = 8,
  parameter int T_ACT = 3,
  parameter int T_PRE = 3,
  parameter int T_COL = 1,
  parameter int T_RFC = 8,
  localparam int CNT_W = $clog2(T_ACT + T_PRE + T_COL + T_RFC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [2:0]       kind,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             idle
);
  import dsch_pkg::*;
  logic [CNT_W-1:0] busy;
  logic [CNT_W-1:0] load;

  always_comb begin
    case (cmd_e'(kind))
      CMD_ACT: load = CNT_W'(T_ACT - 1);
      CMD_PRE: load = CNT_W'(T_PRE - 1);
      CMD_REF: load = CNT_W'(T_RFC - 1);
      default: load = ap ? CNT_W'(T_COL + T_PRE - 1) : CNT_W'(T_COL - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      busy     <= '0;
    end else if (issue) begin
      busy <= load;
      case (cmd_e'(kind))
        CMD_ACT: begin
          is_open  <= 1'b1;
          open_row <= row_in;
        end
        CMD_PRE, CMD_REF: is_open <= 1'b0;
        default: if (ap) is_open <= 1'b0;
      endcase
    end else if (busy != '0) begin
      busy <= busy - 1'b1;
    end
  end

  assign idle = (busy == '0);
endmodule

// File: rtl/dsch_refresh.sv
// Periodic refresh request, held until the REF command is issued.
module dsch_refresh #(
  parameter int REF_INT = 3000,
  localparam int CNT_W = $clog2(REF_INT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_issued,
  output logic pend
);
  logic [CNT_W-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (ref_issued) pend <= 1'b0;
      if (tick == CNT_W'(REF_INT - 1)) begin
        tick <= '0;
        pend <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsch_top.sv
module dsch_top #(
  parameter int NBANK   = 4,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 6,
  parameter int TAG_W   = 4,
  parameter int DEPTH   = 8,
  parameter int T_ACT   = 3,
  parameter int T_PRE   = 3,
  parameter int T_COL   = 1,
  parameter int T_RFC   = 8,
  parameter int REF_INT = 3000,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ENT_W  = 1 + TAG_W + BANK_W + ROW_W + COL_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int QCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              close_page,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag
);
  import dsch_pkg::*;

  localparam int ROW_LO  = COL_W;
  localparam int BANK_LO = COL_W + ROW_W;
  localparam int TAG_LO  = BANK_LO + BANK_W;
  localparam int WR_BIT  = TAG_LO + TAG_W;

  logic [DEPTH-1:0][ENT_W-1:0] slots;
  logic [DEPTH-1:0]            slot_vld;
  logic [QCNT_W-1:0]           q_count;
  logic                        q_full;
  logic                        q_push, q_pop;
  logic                        ref_pend;

  logic [NBANK-1:0]            b_open, b_idle, b_issue;
  logic [NBANK-1:0][ROW_W-1:0] b_row;

  // Decoded view of each queue slot.
  logic [DEPTH-1:0]              e_wr, e_hit, e_ok;
  logic [DEPTH-1:0][BANK_W-1:0]  e_bank;
  logic [DEPTH-1:0][ROW_W-1:0]   e_row;
  logic [DEPTH-1:0][COL_W-1:0]   e_col;
  logic [DEPTH-1:0][TAG_W-1:0]   e_tag;
  cmd_e [DEPTH-1:0]              e_kind;

  // Chosen command.
  logic              n_fire, n_ap, n_done;
  cmd_e              n_kind;
  logic [BANK_W-1:0] n_bank;
  logic [ROW_W-1:0]  n_row;
  logic [COL_W-1:0]  n_col;
  logic [TAG_W-1:0]  n_tag;
  logic [IDX_W-1:0]  sel_idx;

  assign q_push    = req_valid && !q_full;
  assign req_ready = !q_full;

  dsch_queue #(.DEPTH(DEPTH), .W(ENT_W)) queue_i (
    .clk(clk), .rst_n(rst_n),
    .push(q_push),
    .push_data({req_write, req_tag, req_bank, req_row, req_col}),
    .pop(q_pop), .pop_idx(sel_idx),
    .slots(slots), .slot_vld(slot_vld), .count(q_count), .full(q_full)
  );

  dsch_refresh #(.REF_INT(REF_INT)) refresh_i (
    .clk(clk), .rst_n(rst_n),
    .ref_issued(n_fire && n_kind == CMD_REF),
    .pend(ref_pend)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign b_issue[b] = n_fire && (n_kind == CMD_REF || n_bank == BANK_W'(b));
      dsch_bank #(.ROW_W(ROW_W), .T_ACT(T_ACT), .T_PRE(T_PRE), .T_COL(T_COL),
                  .T_RFC(T_RFC)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .issue(b_issue[b]), .kind(n_kind), .ap(n_ap), .row_in(n_row),
        .is_open(b_open[b]), .open_row(b_row[b]), .idle(b_idle[b])
      );
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign e_col[i]  = slots[i][COL_W-1:0];
      assign e_row[i]  = slots[i][ROW_LO +: ROW_W];
      assign e_bank[i] = slots[i][BANK_LO +: BANK_W];
      assign e_tag[i]  = slots[i][TAG_LO +: TAG_W];
      assign e_wr[i]   = slots[i][WR_BIT];
      assign e_hit[i]  = b_open[e_bank[i]] && (b_row[e_bank[i]] == e_row[i]);
      assign e_ok[i]   = slot_vld[i] && b_idle[e_bank[i]] && !ref_pend;
      assign e_kind[i] = e_hit[i] ? (e_wr[i] ? CMD_WR : CMD_RD)
                       : (b_open[e_bank[i]] ? CMD_PRE : CMD_ACT);
    end
  endgenerate

  // Slot selection: the lowest index is the oldest, so it wins by loop order.
  logic             hit_f, any_f, q_fire;
  logic [IDX_W-1:0] hit_idx, any_idx;
  always_comb begin
    hit_f = 1'b0; any_f = 1'b0;
    hit_idx = '0; any_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (e_ok[i]) begin
        any_f = 1'b1; any_idx = IDX_W'(i);
      end
      if (e_ok[i] && e_hit[i]) begin
        hit_f = 1'b1; hit_idx = IDX_W'(i);
      end
    end
    if (fifo_mode) begin
      q_fire  = e_ok[0];
      sel_idx = '0;
    end else begin
      q_fire  = any_f;
      sel_idx = hit_f ? hit_idx : any_idx;
    end
  end

  // Refresh drain: precharge open idle banks, then REF once all are closed and idle.
  logic              rp_f, r_ref;
  logic [BANK_W-1:0] rp_bank;
  always_comb begin
    rp_f = 1'b0; rp_bank = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (b_open[b] && b_idle[b]) begin
        rp_f = 1'b1; rp_bank = BANK_W'(b);
      end
    end
    r_ref = !rp_f && (b_open == '0) && (&b_idle);
  end

  always_comb begin
    n_fire = 1'b0; n_kind = CMD_ACT; n_bank = '0; n_row = '0;
    n_col = '0; n_ap = 1'b0; n_done = 1'b0; n_tag = '0; q_pop = 1'b0;
    if (ref_pend) begin
      if (rp_f) begin
        n_fire = 1'b1; n_kind = CMD_PRE; n_bank = rp_bank; n_row = b_row[rp_bank];
      end else if (r_ref) begin
        n_fire = 1'b1; n_kind = CMD_REF;
      end
    end else if (q_fire) begin
      n_fire = 1'b1;
      n_kind = e_kind[sel_idx];
      n_bank = e_bank[sel_idx];
      n_row  = (n_kind == CMD_PRE) ? b_row[n_bank] : e_row[sel_idx];
      if (n_kind == CMD_RD || n_kind == CMD_WR) begin
        n_col  = e_col[sel_idx];
        n_ap   = close_page;
        n_done = 1'b1;
        n_tag  = e_tag[sel_idx];
        q_pop  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_kind   <= 3'd0;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      cmd_ap     <= 1'b0;
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      cmd_valid  <= n_fire;
      cmd_kind   <= n_kind;
      cmd_bank   <= n_bank;
      cmd_row    <= n_row;
      cmd_col    <= n_col;
      cmd_ap     <= n_ap;
      done_valid <= n_done;
      done_tag   <= n_tag;
    end
  end
endmodule

// File: rtl/dsch_chk.sv
module dsch_chk #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int DEPTH  = 8,
  parameter int T_ACT  = 3,
  parameter int T_PRE  = 3,
  parameter int T_COL  = 1,
  parameter int T_RFC  = 8,
  localparam int BANK_W = $clog2(NBANK),
  localparam int QCNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              close_page,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              cmd_ap,
  input logic              done_valid,
  input logic              ref_pend,
  input logic [QCNT_W-1:0] q_count
);
  import dsch_pkg::*;

  logic is_col;
  assign is_col = cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_WR);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_trk
      logic [7:0]       since, need;
      logic             open_q;
      logic [ROW_W-1:0] row_q;
      logic             hit_b;
      assign hit_b = cmd_valid && (cmd_kind == CMD_REF || cmd_bank == BANK_W'(b));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          since <= 8'hff; need <= '0; open_q <= 1'b0; row_q <= '0;
        end else if (hit_b) begin
          since <= 8'd1;
          case (cmd_kind)
            CMD_ACT: begin need <= 8'(T_ACT); open_q <= 1'b1; row_q <= cmd_row; end
            CMD_PRE: begin need <= 8'(T_PRE); open_q <= 1'b0; end
            CMD_REF: begin need <= 8'(T_RFC); open_q <= 1'b0; end
            default: begin
              need <= cmd_ap ? 8'(T_COL + T_PRE) : 8'(T_COL);
              if (cmd_ap) open_q <= 1'b0;
            end
          endcase
        end else if (since != 8'hff) begin
          since <= since + 8'd1;
        end
      end

      AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |-> since >= need); // R2
      AST_COL_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && cmd_bank == BANK_W'(b)) |-> (open_q && row_q == cmd_row)); // R1
      AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT && cmd_bank == BANK_W'(b)) |-> !open_q); // R1
    end
  endgenerate

  AST_DONE_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> is_col); // R3
  AST_CLOSE_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && $past(close_page)) |-> cmd_ap); // R7
  AST_REF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_pend) && cmd_valid) |-> (cmd_kind == CMD_PRE || cmd_kind == CMD_REF)); // R8
  AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == QCNT_W'(DEPTH)) == !req_ready); // R9
endmodule

bind dsch_top dsch_chk #(
  .NBANK(NBANK), .ROW_W(ROW_W), .DEPTH(DEPTH), .T_ACT(T_ACT),
  .T_PRE(T_PRE), .T_COL(T_COL), .T_RFC(T_RFC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .close_page(close_page), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
  .cmd_row(cmd_row), .cmd_ap(cmd_ap), .done_valid(done_valid),
  .ref_pend(ref_pend), .q_count(q_count)
);

// File: tb/dsch_top_tb_top.sv
module dsch_top_tb_top;
  localparam int NBANK = 4, ROW_W = 8, COL_W = 6, TAG_W = 4, DEPTH = 8;
  localparam int T_ACT = 3, T_PRE = 3, T_COL = 1, T_RFC = 8, REF_INT = 1000;
  localparam int BANK_W = $clog2(NBANK);
  localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_PRE = 3, K_REF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 1'b0, close_page = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic cmd_valid, cmd_ap, done_valid;
  logic [2:0] cmd_kind;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [TAG_W-1:0] done_tag;

  always #4 clk = ~clk; // 125 MHz

  dsch_top #(.NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
             .DEPTH(DEPTH), .T_ACT(T_ACT), .T_PRE(T_PRE), .T_COL(T_COL),
             .T_RFC(T_RFC), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .close_page(close_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_tag(req_tag), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .done_valid(done_valid), .done_tag(done_tag));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int accepted = 0, completed = 0;
  int exp_q[$];
  bit sb_ordered = 1'b1;
  bit exp_wr[16];
  int done_log[64];
  int done_n = 0;
  int last_done_cyc = 0;
  int klog[4096];
  int blog[4096];
  int aplog[4096];
  int cmd_n = 0;
  int ref_cyc[8];
  int ref_n = 0;
  bit m_open[NBANK];
  int m_row[NBANK];
  int m_last[NBANK];
  int m_need[NBANK];
  bit saw_full = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NBANK; b++) begin
      m_open[b] = 1'b0; m_row[b] = 0; m_last[b] = -1000; m_need[b] = 0;
    end
    exp_q.delete();
    done_n = 0; cmd_n = 0; ref_n = 0; accepted = 0; completed = 0;
  endtask

  // Monitor: command legality and scoreboard, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmd_valid) begin
      if (cmd_n < 4096) begin
        klog[cmd_n] = int'(cmd_kind); blog[cmd_n] = int'(cmd_bank); aplog[cmd_n] = int'(cmd_ap);
      end
      cmd_n++;
      if (cmd_kind == 3'(K_REF)) begin
        for (int b = 0; b < NBANK; b++) begin
          chk(cyc - m_last[b] >= m_need[b], "R2 gap before REF", cyc - m_last[b], m_need[b]);
          chk(!m_open[b], "R8 REF with open bank", int'(m_open[b]), 0);
          m_open[b] = 1'b0; m_last[b] = cyc; m_need[b] = T_RFC;
        end
        if (ref_n < 8) ref_cyc[ref_n] = cyc;
        ref_n++;
      end else begin
        int b;
        b = int'(cmd_bank);
        chk(cyc - m_last[b] >= m_need[b], "R2 bank gap", cyc - m_last[b], m_need[b]);
        m_last[b] = cyc;
        case (int'(cmd_kind))
          K_ACT: begin
            chk(!m_open[b], "R1 ACT to open bank", int'(m_open[b]), 0);
            m_open[b] = 1'b1; m_row[b] = int'(cmd_row); m_need[b] = T_ACT;
          end
          K_PRE: begin
            m_open[b] = 1'b0; m_need[b] = T_PRE;
          end
          default: begin
            chk(m_open[b] && m_row[b] == int'(cmd_row), "R1 column row", int'(cmd_row), m_row[b]);
            m_need[b] = cmd_ap ? T_COL + T_PRE : T_COL;
            if (cmd_ap) m_open[b] = 1'b0;
          end
        endcase
      end
    end
    if (rst_n && done_valid) begin
      int t;
      t = int'(done_tag);
      completed++;
      last_done_cyc = cyc;
      if (done_n < 64) done_log[done_n] = t;
      done_n++;
      chk(cmd_valid && int'(cmd_kind) == (exp_wr[t] ? K_WR : K_RD), "R3 column kind",
          int'(cmd_kind), exp_wr[t] ? K_WR : K_RD);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected completion", t, -1);
      end else if (sb_ordered) begin
        int e;
        e = exp_q.pop_front();
        chk(t == e, "R4 completion order", t, e);
      end else begin
        int idx;
        idx = -1;
        foreach (exp_q[k]) if (idx < 0 && exp_q[k] == t) idx = k;
        chk(idx >= 0, "R3 completion tag", t, -1);
        if (idx >= 0) exp_q.delete(idx);
      end
    end
  end

  task automatic do_reset(input bit fifo, input bit closep);
    @(negedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; fifo_mode = fifo; close_page = closep;
    repeat (3) @(negedge clk);
    #1; model_reset(); rst_n = 1'b1;
  endtask

  task automatic send(input bit w, input int bank, input int row, input int col, input int tag);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = w; req_bank = BANK_W'(bank);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_tag = TAG_W'(tag);
    while (!req_ready) begin
      saw_full = 1'b1;
      chk(accepted - completed == DEPTH, "R9 ready low only when full", accepted - completed, DEPTH);
      @(negedge clk); #1;
    end
    @(posedge clk);
    accepted++;
    exp_wr[tag] = w;
    exp_q.push_back(tag);
  endtask

  task automatic idle_wait();
    @(negedge clk); #1;
    req_valid = 1'b0;
    for (int k = 0; k < 2000 && completed < accepted; k++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(completed == accepted, "R3 all requests completed", completed, accepted);
  endtask

  task automatic ref_seq(output int span);
    int t0;
    t0 = cyc;
    for (int i = 0; i < 8; i++) send(i[0], 0, (i % 2) + 1, i, i);
    idle_wait();
    span = last_done_cyc - t0;
  endtask

  initial begin
    int fifo_span, fr_span, start_i, first_b0, act_n, pre_n, fr_idx;
    bit ap_all;
    fork
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    // R11 reset state
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R11 no command after reset", int'(cmd_valid), 0);
    chk(done_valid == 1'b0, "R11 no completion after reset", int'(done_valid), 0);

    // R4, R10: reference sequence in strict FIFO order
    sb_ordered = 1'b1;
    ref_seq(fifo_span);

    // R5, R10: same sequence with open-row hits first
    do_reset(1'b0, 1'b0);
    sb_ordered = 1'b0;
    ref_seq(fr_span);
    chk(fr_span < fifo_span, "R10 first-ready faster than FIFO", fr_span, fifo_span);
    for (int i = 0; i < 8; i++) begin
      fr_idx = (i < 4) ? 2 * i : 2 * (i - 4) + 1;
      chk(done_log[i] == fr_idx, "R5 hit-first completion order", done_log[i], fr_idx);
    end

    // R6: open row 2 of bank 0 is kept; a new hit needs no ACT
    start_i = cmd_n;
    send(1'b0, 0, 2, 9, 8);
    idle_wait();
    first_b0 = -1;
    for (int i = start_i; i < cmd_n; i++) if (first_b0 < 0 && blog[i] == 0) first_b0 = klog[i];
    chk(first_b0 == K_RD, "R6 open row reused without ACT", first_b0, K_RD);

    // R7: close-page policy
    do_reset(1'b0, 1'b1);
    sb_ordered = 1'b1;
    send(1'b1, 2, 3, 1, 1);
    idle_wait();
    send(1'b0, 2, 3, 2, 2);
    idle_wait();
    act_n = 0; pre_n = 0; ap_all = 1'b1;
    for (int i = 0; i < cmd_n; i++) begin
      if (klog[i] == K_ACT) act_n++;
      if (klog[i] == K_PRE) pre_n++;
      if ((klog[i] == K_RD || klog[i] == K_WR) && aplog[i] != 1) ap_all = 1'b0;
    end
    chk(act_n == 2, "R7 each access activates", act_n, 2);
    chk(pre_n == 0, "R7 no explicit precharge", pre_n, 0);
    chk(ap_all, "R7 auto-precharge flag", int'(ap_all), 1);

    // R9: fill the queue with conflicting requests in FIFO order
    do_reset(1'b1, 1'b0);
    sb_ordered = 1'b1;
    saw_full = 1'b0;
    for (int i = 0; i < 12; i++) send(1'b0, 0, (i % 2) + 1, i, i);
    idle_wait();
    chk(saw_full, "R9 ready dropped when full", int'(saw_full), 1);
    chk(completed == 12, "R9 no request lost", completed, 12);

    // R8: refresh with one bank left open
    do_reset(1'b0, 1'b0);
    send(1'b0, 3, 9, 0, 3);
    idle_wait();
    for (int k = 0; k < 4 * REF_INT && ref_n < 3; k++) @(negedge clk);
    chk(ref_n >= 3, "R8 refresh issued periodically", ref_n, 3);
    start_i = -1;
    for (int i = 0; i < cmd_n; i++) if (start_i < 0 && klog[i] == K_REF) start_i = i;
    chk(start_i > 0 && klog[start_i - 1] == K_PRE && blog[start_i - 1] == 3,
        "R8 open bank precharged before REF", start_i > 0 ? klog[start_i - 1] : -1, K_PRE);
    chk(ref_cyc[2] - ref_cyc[1] == REF_INT, "R8 refresh interval", ref_cyc[2] - ref_cyc[1], REF_INT);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule